// File: doc/BRIEF.md
# Activation Lookup and Operand Presence Store

This block keeps the bookkeeping a dataflow processing element needs to pair up the two operands of a two-input instruction. It has two layers. The first is an eight-entry table that turns a 3-bit activation id into a valid flag and a 2-bit frame number. The second is a presence store holding one presence bit and one port bit for each of the eight matchable offsets in each of four frames. A lookup runs through both layers within one cycle and yields a result class. The table is written by frame allocation and release commands on a write port that is separate from the lookup port.

Each lookup falls into one of four result classes. NONE means no request. FAULT means the activation is unmapped, or the same port is already waiting. PARK means a first operand has arrived, and the store records presence and port. FIRE means the partner is waiting on the opposite port, and the presence bit is consumed. Every update lands at the next clock edge, so a lookup in the same cycle as a write sees the old contents. Operand data and the frame memory itself live elsewhere.

Top module: `match_meta_store`

## Requirements
- R1: After reset every activation entry is invalid and every presence bit is clear, so any lookup reports an error.
- R2: An allocate command (cmd_op=0) at activation a with frame f makes later lookups of a report frame f with no error.
- R3: A free command (cmd_op=1) at activation a makes later lookups of a report an error.
- R4: A lookup in the same cycle as a command to the same activation returns the entry's contents from before the command. The new contents are visible from the next cycle.
- R5: A command and a lookup of a different activation proceed in the same cycle without affecting each other.
- R6: A lookup of a valid activation whose offset is not present raises lk_park and records presence together with the incoming port. A lookup of the same offset in a later cycle on the other port raises lk_hit.
- R7: A lookup with presence set and an incoming port that differs from the stored port raises lk_hit and clears that presence bit.
- R8: A lookup with presence set and the same port as the stored one raises lk_err and leaves the store unchanged.
- R9: A lookup of an invalid activation raises lk_err and changes no presence bit.
- R10: Each frame holds a separate 4-bit word per pair of offsets. offset[2:1] picks the word. offset[0]=0 picks bits {presence,port} in [3:2] and offset[0]=1 picks bits [1:0]. Neighbouring offsets and different frames are independent.
- R11: Freeing a valid activation clears every presence bit of the frame it mapped. This clear overrides a park into that frame in the same cycle. Freeing an invalid activation clears nothing.
- R12: With lk_req low, lk_hit, lk_park and lk_err are all low. When lk_req is high, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe for the table write port |
| cmd_op | input | 1 | 0 = allocate, 1 = free |
| cmd_act | input | 3 | Activation id the command targets |
| cmd_frame | input | 2 | Frame number bound by an allocate |
| lk_req | input | 1 | Lookup request |
| lk_act | input | 3 | Activation id of the incoming token |
| lk_offset | input | 3 | Instruction offset within the frame |
| lk_port | input | 1 | Port of the incoming operand |
| lk_hit | output | 1 | Partner waiting, pair completes |
| lk_park | output | 1 | First operand, presence recorded |
| lk_err | output | 1 | Unmapped activation or duplicate port |
| lk_frame | output | 2 | Frame number read from the table |
| lk_present | output | 1 | Presence bit read for the offset |
| lk_stored_port | output | 1 | Port bit read for the offset |

## Verification
The bench puts commands and lookups to the same activation in one cycle and expects the old mapping. A design that forwarded the write would report a park where an error is due. It parks on offsets that share a word and on the same offset in two frames. Crossed bit pairs or a wrong word decode would turn those into false hits. It frees a frame in the same cycle as a park into it, then maps the frame to a new activation and expects empty slots. Stale presence or the wrong priority would show up as a hit. It also checks that fault lookups (a duplicate port or an unmapped id) leave no trace, and that freeing an unmapped id spares the other frames.

// File: rtl/mms_pkg.sv
package mms_pkg;
    localparam int ACT_W   = 3;
    localparam int FRAME_W = 2;
    localparam int OFF_W   = 3;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_PARK  = 2'd1,
        RES_FIRE  = 2'd2,
        RES_FAULT = 2'd3
    } res_e;

    typedef enum logic {
        CMD_ALLOC = 1'b0,
        CMD_FREE  = 1'b1
    } cmd_e;
endpackage

// File: rtl/mms_act_table.sv
module mms_act_table
    import mms_pkg::*;
#(
    parameter int AW = ACT_W,
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          free_en,
    input  logic [AW-1:0] wr_act,
    input  logic [FW-1:0] wr_frame,
    input  logic [AW-1:0] rd_act,
    output logic          rd_valid,
    output logic [FW-1:0] rd_frame,
    output logic          peek_valid,
    output logic [FW-1:0] peek_frame
);
    localparam int NUM_ACT = 1 << AW;

    logic          valid_q [NUM_ACT];
    logic [FW-1:0] frame_q [NUM_ACT];

    for (genvar a = 0; a < NUM_ACT; a++) begin : g_ent
        logic hit_w;
        assign hit_w = (wr_act == AW'(a));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[a] <= 1'b0;
                frame_q[a] <= '0;
            end else if (alloc_en && hit_w) begin
                valid_q[a] <= 1'b1;
                frame_q[a] <= wr_frame;
            end else if (free_en && hit_w) begin
                valid_q[a] <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_valid   = valid_q[rd_act];
        rd_frame   = frame_q[rd_act];
        peek_valid = valid_q[wr_act];
        peek_frame = frame_q[wr_act];
    end
endmodule

// File: rtl/mms_presence.sv
module mms_presence
    import mms_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] rd_frame,
    input  logic [OW-1:0] rd_off,
    output logic          rd_present,
    output logic          rd_port,
    input  logic          upd_set,
    input  logic          upd_clr,
    input  logic [FW-1:0] upd_frame,
    input  logic [OW-1:0] upd_off,
    input  logic          upd_port,
    input  logic          wipe_en,
    input  logic [FW-1:0] wipe_frame
);
    localparam int NUM_FRAMES = 1 << FW;
    localparam int GW         = OW - 1;
    localparam int NUM_GRP    = 1 << GW;

    // word layout: [3]=presence even, [2]=port even, [1]=presence odd, [0]=port odd
    logic [3:0] word_q [NUM_FRAMES][NUM_GRP];

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            logic sel_w;
            assign sel_w = (upd_frame == FW'(f)) && (upd_off[OW-1:1] == GW'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q[f][g] <= 4'b0000;
                end else if (wipe_en && wipe_frame == FW'(f)) begin
                    word_q[f][g] <= 4'b0000;
                end else if (sel_w && upd_set) begin
                    if (upd_off[0]) word_q[f][g][1:0] <= {1'b1, upd_port};
                    else            word_q[f][g][3:2] <= {1'b1, upd_port};
                end else if (sel_w && upd_clr) begin
                    if (upd_off[0]) word_q[f][g][1] <= 1'b0;
                    else            word_q[f][g][3] <= 1'b0;
                end
            end
        end
    end

    logic [3:0] rd_word;
    logic [1:0] rd_pair;
    always_comb begin
        rd_word    = word_q[rd_frame][rd_off[OW-1:1]];
        rd_pair    = rd_off[0] ? rd_word[1:0] : rd_word[3:2];
        rd_present = rd_pair[1];
        rd_port    = rd_pair[0];
    end
endmodule

// File: rtl/mms_classify.sv
module mms_classify
    import mms_pkg::*;
(
    input  logic req,
    input  logic valid,
    input  logic present,
    input  logic stored_port,
    input  logic port,
    output res_e res
);
    always_comb begin
        res = RES_NONE;
        unique case ({req, valid, present})
            3'b100, 3'b101: res = RES_FAULT;
            3'b110:         res = RES_PARK;
            3'b111:         res = (port != stored_port) ? RES_FIRE : RES_FAULT;
            default:        res = RES_NONE;
        endcase
    end
endmodule

// File: rtl/match_meta_store.sv
module match_meta_store
    import mms_pkg::*;
#(
    parameter int AW = ACT_W,
    parameter int FW = FRAME_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [AW-1:0] cmd_act,
    input  logic [FW-1:0] cmd_frame,
    input  logic          lk_req,
    input  logic [AW-1:0] lk_act,
    input  logic [OW-1:0] lk_offset,
    input  logic          lk_port,
    output logic          lk_hit,
    output logic          lk_park,
    output logic          lk_err,
    output logic [FW-1:0] lk_frame,
    output logic          lk_present,
    output logic          lk_stored_port
);
    logic          alloc_en, free_en;
    logic          rd_valid, peek_valid;
    logic [FW-1:0] rd_frame, peek_frame;
    logic          pres_w, port_w;
    res_e          res;

    assign alloc_en = cmd_valid && (cmd_e'(cmd_op) == CMD_ALLOC);
    assign free_en  = cmd_valid && (cmd_e'(cmd_op) == CMD_FREE);

    mms_act_table #(.AW(AW), .FW(FW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .free_en    (free_en),
        .wr_act     (cmd_act),
        .wr_frame   (cmd_frame),
        .rd_act     (lk_act),
        .rd_valid   (rd_valid),
        .rd_frame   (rd_frame),
        .peek_valid (peek_valid),
        .peek_frame (peek_frame)
    );

    mms_presence #(.FW(FW), .OW(OW)) u_pres (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_frame   (rd_frame),
        .rd_off     (lk_offset),
        .rd_present (pres_w),
        .rd_port    (port_w),
        .upd_set    (res == RES_PARK),
        .upd_clr    (res == RES_FIRE),
        .upd_frame  (rd_frame),
        .upd_off    (lk_offset),
        .upd_port   (lk_port),
        .wipe_en    (free_en && peek_valid),
        .wipe_frame (peek_frame)
    );

    mms_classify u_cls (
        .req         (lk_req),
        .valid       (rd_valid),
        .present     (pres_w),
        .stored_port (port_w),
        .port        (lk_port),
        .res         (res)
    );

    always_comb begin
        lk_hit  = 1'b0;
        lk_park = 1'b0;
        lk_err  = 1'b0;
        unique case (res)
            RES_PARK:  lk_park = 1'b1;
            RES_FIRE:  lk_hit  = 1'b1;
            RES_FAULT: lk_err  = 1'b1;
            default:   ;
        endcase
        lk_frame       = rd_frame;
        lk_present     = pres_w;
        lk_stored_port = port_w;
    end
endmodule

// File: rtl/mms_checker.sv
module mms_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_op,
    input logic [2:0] cmd_act,
    input logic [1:0] cmd_frame,
    input logic       lk_req,
    input logic [2:0] lk_act,
    input logic [2:0] lk_offset,
    input logic       lk_port,
    input logic       lk_hit,
    input logic       lk_park,
    input logic       lk_err,
    input logic [1:0] lk_frame,
    input logic       lk_present
);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_park || lk_err));

    // R12
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_park, lk_err}) == 1);

    // R7
    hit_needs_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_present);

    // R2
    alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && $past(rst_n && cmd_valid && !cmd_op) && lk_act == $past(cmd_act)
        |-> !lk_err && lk_frame == $past(cmd_frame));

    // R3
    free_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && $past(rst_n && cmd_valid && cmd_op) && lk_act == $past(cmd_act)
        |-> lk_err);

    // R6
    park_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lk_park && !cmd_valid) && lk_req && lk_act == $past(lk_act)
        && lk_offset == $past(lk_offset) && lk_port != $past(lk_port)
        |-> lk_hit);

    // R7
    hit_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lk_hit && !cmd_valid) && lk_req && lk_act == $past(lk_act)
        && lk_offset == $past(lk_offset) |-> !lk_hit);
endmodule

bind match_meta_store mms_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_act    (cmd_act),
    .cmd_frame  (cmd_frame),
    .lk_req     (lk_req),
    .lk_act     (lk_act),
    .lk_offset  (lk_offset),
    .lk_port    (lk_port),
    .lk_hit     (lk_hit),
    .lk_park    (lk_park),
    .lk_err     (lk_err),
    .lk_frame   (lk_frame),
    .lk_present (lk_present)
);

// File: tb/match_meta_store_test.sv
module match_meta_store_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [2:0] cmd_act = '0;
    logic [1:0] cmd_frame = '0;
    logic       lk_req = 1'b0;
    logic [2:0] lk_act = '0, lk_offset = '0;
    logic       lk_port = 1'b0;
    logic       lk_hit, lk_park, lk_err, lk_present, lk_stored_port;
    logic [1:0] lk_frame;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    match_meta_store uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_act(cmd_act), .cmd_frame(cmd_frame), .lk_req(lk_req),
        .lk_act(lk_act), .lk_offset(lk_offset), .lk_port(lk_port),
        .lk_hit(lk_hit), .lk_park(lk_park), .lk_err(lk_err),
        .lk_frame(lk_frame), .lk_present(lk_present),
        .lk_stored_port(lk_stored_port)
    );

    typedef struct packed {
        logic       cv;
        logic       op;
        logic [2:0] ca;
        logic [1:0] cf;
        logic       lr;
        logic [2:0] la;
        logic [2:0] lo;
        logic       lp;
        logic       eh;
        logic       ep;
        logic       ee;
        logic [1:0] ef;
        logic [4:0] tag;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd0,1'b0, 1'b0,1'b0,1'b1,2'd0, 5'd1},  // R1 empty table
        '{1'b1,1'b0,3'd2,2'd1, 1'b1,3'd2,3'd0,1'b0, 1'b0,1'b0,1'b1,2'd0, 5'd4},  // R4 alloc seen late
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd3,1'b0, 1'b0,1'b1,1'b0,2'd1, 5'd2},  // R2 mapped, parks
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd3,1'b0, 1'b0,1'b0,1'b1,2'd1, 5'd8},  // R8 same port
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd3,1'b1, 1'b1,1'b0,1'b0,2'd1, 5'd7},  // R7 pair
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd3,1'b1, 1'b0,1'b1,1'b0,2'd1, 5'd7},  // R7 consumed
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd2,1'b1, 1'b0,1'b1,1'b0,2'd1, 5'd10}, // R10 even neighbour
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd2,1'b0, 1'b1,1'b0,1'b0,2'd1, 5'd10}, // R10
        '{1'b1,1'b0,3'd5,2'd2, 1'b1,3'd5,3'd3,1'b0, 1'b0,1'b0,1'b1,2'd0, 5'd4},  // R4
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd5,3'd3,1'b0, 1'b0,1'b1,1'b0,2'd2, 5'd10}, // R10 other frame
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd2,3'd3,1'b0, 1'b1,1'b0,1'b0,2'd1, 5'd10}, // R10 frame 1 intact
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd5,3'd7,1'b1, 1'b0,1'b1,1'b0,2'd2, 5'd6},  // R6
        '{1'b1,1'b1,3'd5,2'd0, 1'b1,3'd5,3'd0,1'b0, 1'b0,1'b1,1'b0,2'd2, 5'd11}, // R11 free vs park
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd5,3'd7,1'b0, 1'b0,1'b0,1'b1,2'd0, 5'd3},  // R3
        '{1'b1,1'b0,3'd6,2'd2, 1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b0,2'd0, 5'd12}, // R12 idle
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd6,3'd7,1'b0, 1'b0,1'b1,1'b0,2'd2, 5'd11}, // R11 wiped
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd6,3'd0,1'b1, 1'b0,1'b1,1'b0,2'd2, 5'd11}, // R11 free won
        '{1'b1,1'b0,3'd0,2'd3, 1'b1,3'd6,3'd7,1'b1, 1'b1,1'b0,1'b0,2'd2, 5'd5},  // R5
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd0,3'd1,1'b0, 1'b0,1'b1,1'b0,2'd3, 5'd2},  // R2
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd0,3'd1,1'b1, 1'b1,1'b0,1'b0,2'd3, 5'd10}, // R10 odd slot
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd6,3'd5,1'b0, 1'b0,1'b1,1'b0,2'd2, 5'd6},  // R6
        '{1'b1,1'b1,3'd4,2'd0, 1'b0,3'd0,3'd0,1'b0, 1'b0,1'b0,1'b0,2'd0, 5'd12}, // R12
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd6,3'd5,1'b1, 1'b1,1'b0,1'b0,2'd2, 5'd11}, // R11 unmapped free
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd5,3'd4,1'b0, 1'b0,1'b0,1'b1,2'd0, 5'd9},  // R9
        '{1'b0,1'b0,3'd0,2'd0, 1'b1,3'd6,3'd4,1'b1, 1'b0,1'b1,1'b0,2'd2, 5'd9}   // R9 untouched
    };

    task automatic check_out(input int tag, input logic eh, input logic ep,
                             input logic ee, input logic [1:0] ef);
        logic [4:0] got, exp;
        logic       use_f;
        use_f = eh | ep;
        got = {lk_hit, lk_park, lk_err, use_f ? lk_frame : 2'b00};
        exp = {eh, ep, ee, use_f ? ef : 2'b00};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d: {hit,park,err,frame} actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid = 1'b0; cmd_op = 1'b0; cmd_act = '0; cmd_frame = '0;
        lk_req = 1'b0; lk_act = '0; lk_offset = '0; lk_port = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: every activation unmapped
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            lk_req = 1'b1; lk_act = 3'(a); lk_offset = 3'(a); lk_port = 1'b0;
            #2;
            check_out(1, 1'b0, 1'b0, 1'b1, 2'd0);
        end

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cmd_valid = VECS[i].cv; cmd_op = VECS[i].op;
            cmd_act = VECS[i].ca; cmd_frame = VECS[i].cf;
            lk_req = VECS[i].lr; lk_act = VECS[i].la;
            lk_offset = VECS[i].lo; lk_port = VECS[i].lp;
            #2;
            check_out(int'(VECS[i].tag), VECS[i].eh, VECS[i].ep, VECS[i].ee, VECS[i].ef);
        end

        // R1 reset mid-run clears the table again
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        lk_req = 1'b1; lk_act = 3'd6; lk_offset = 3'd4; lk_port = 1'b0;
        #2;
        check_out(1, 1'b0, 1'b0, 1'b1, 2'd0);

        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule